// File: doc/BRIEF.md
# Global history branch direction predictor

This block guesses whether the next conditional branch will be taken by looking only at how the most recent branches resolved. It keeps a shift register of the last few outcomes, where 1 means taken and 0 means not taken. The whole register is used as a direct index into a table of two-bit saturating counters. The selected counter's upper bit is the prediction. The branch address is never used, so the table learns patterns that repeat across neighbouring branches rather than the habits of one branch.

The fetch side reads `pred_taken` together with `pred_index`, the history value that produced the guess, and keeps that index alongside the branch. When the branch resolves, the execute side returns the index with the real outcome on the update port. The counter at that index steps toward the outcome, and the outcome enters the history register at its least significant end. The oldest outcome falls off the top. Because the index travels with the branch, the correct counter is trained even if the history has moved on since the prediction.

Top module: `ghist_predictor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the history register is cleared to all zeros and every counter is set to 2 (binary 10). After reset, therefore, `pred_index` is 0 and `pred_taken` is 1.
- R2: `pred_index` always equals the current history register. `pred_taken` is 1 exactly when the counter selected by that value is 2 or 3.
- R3: On an edge where `upd_valid` is 1, the new history is the old history shifted left by one place, with `upd_taken` in bit 0; the old most significant bit is discarded.
- R4: On a taken update, the counter at `upd_index` goes up by one. A counter that is already at 3 stays at 3.
- R5: On a not-taken update, the counter at `upd_index` goes down by one. A counter that is already at 0 stays at 0.
- R6: An update changes only the counter addressed by `upd_index`, even when that index differs from the current history. All other counters keep their values.
- R7: On an edge where `upd_valid` is 0, neither the history nor any counter changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_taken | output | 1 | Prediction for the current history: 1 means taken |
| pred_index | output | HIST_W | History value that selected the prediction |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_index | input | HIST_W | Table index that was used when the branch was predicted |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The hardest case to reach from the ports is a counter that sits at a saturation limit and is then trained by an update whose index is not the current history. Only the counter at the live history can be seen, so the result is visible only after the history has been steered back to that index. The stimulus does this in two ways. Directed sequences first drive one index to 3 or to 0 with stale-index updates. Filler outcomes then shift in exactly the bits that bring the history back onto that index. Random traffic mixes live-index and stale-index updates with idle cycles and a mid-run reset, and a bench model of all counters is compared with the prediction after every edge.

// File: rtl/ghp_pkg.sv
// Package ghp_pkg
// Shared counter type and the saturating step rule used by the direction table.
// Assumes a two-bit counter whose upper bit is the taken/not-taken decision.
package ghp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b10;
    localparam ctr_t CTR_MAX  = 2'b11;
    localparam ctr_t CTR_MIN  = 2'b00;

    // Step a counter one place toward the observed outcome, clamping at both ends.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    // Decision carried by a counter: taken when the value is 2 or 3.
    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/ghp_history.sv
// Module ghp_history
// Holds the global outcome history as a shift register. Each accepted outcome
// enters at bit 0 and the oldest bit leaves at the top.
// Assumes HIST_W >= 2 and a synchronous active-low reset.
module ghp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;

    // Clear on reset, otherwise shift in one outcome per accepted update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    assign hist = hist_q;

    AST_HIST_RESET: assert property (@(posedge clk)
        !rst_n |=> hist_q == '0);                                   // R1

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)});  // R3

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));                             // R7

endmodule

// File: rtl/ghp_sat_counter.sv
// Module ghp_sat_counter
// One two-bit saturating counter. It moves toward the outcome when enabled and
// holds otherwise. Assumes the caller gates en to the single addressed entry.
module ghp_sat_counter
    import ghp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic taken,
    output ctr_t state
);

    ctr_t state_q;

    // Start weakly taken after reset; step toward the outcome when selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTR_INIT;
        end else if (en) begin
            state_q <= ctr_step(state_q, taken);
        end
    end

    assign state = state_q;

    AST_CNT_RESET: assert property (@(posedge clk)
        !rst_n |=> state_q == 2'b10);                               // R1

    AST_CNT_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (en && taken && state_q == 2'b11) |=> state_q == 2'b11);    // R4

    AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && taken && state_q != 2'b11) |=> state_q == $past(state_q) + 2'd1);  // R4

    AST_CNT_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !taken && state_q == 2'b00) |=> state_q == 2'b00);   // R5

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !taken && state_q != 2'b00) |=> state_q == $past(state_q) - 2'd1); // R5

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));                                  // R6

endmodule

// File: rtl/ghp_counter_table.sv
// Module ghp_counter_table
// Table of 2**HIST_W saturating counters. One entry is trained per update,
// chosen by wr_idx, and one entry is read combinationally, chosen by rd_idx.
// Assumes at most one write per cycle.
module ghp_counter_table
    import ghp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken,
    input  logic [HIST_W-1:0] rd_idx,
    output logic              rd_taken
);

    localparam int DEPTH = 1 << HIST_W;

    ctr_t             states [DEPTH];
    logic [DEPTH-1:0] entry_en;

    // Decode the write index into one enable per entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            entry_en[i] = wr_en && (wr_idx == HIST_W'(i));
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            ghp_sat_counter u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (entry_en[g]),
                .taken (wr_taken),
                .state (states[g])
            );
        end
    endgenerate

    // Read the selected entry and reduce it to a direction.
    always_comb begin
        rd_taken = ctr_says_taken(states[rd_idx]);
    end

    AST_TBL_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_en));                                        // R6

    AST_TBL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> entry_en == '0);                                 // R7

endmodule

// File: rtl/ghist_predictor.sv
// Module ghist_predictor
// Direction predictor indexed only by global branch history. The prediction
// comes from the counter that the current history selects. An update trains
// the counter named by the index returned with the branch, and then shifts the
// outcome into the history.
// Assumes the caller returns the pred_index it saw at prediction time.
module ghist_predictor #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_index,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_index,
    input  logic              upd_taken
);

    logic [HIST_W-1:0] hist;
    logic              tbl_taken;

    ghp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (hist)
    );

    ghp_counter_table #(.HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_idx   (upd_index),
        .wr_taken (upd_taken),
        .rd_idx   (hist),
        .rd_taken (tbl_taken)
    );

    assign pred_index = hist;
    assign pred_taken = tbl_taken;

    AST_TOP_RESET_PRED: assert property (@(posedge clk)
        !rst_n |=> (pred_taken && pred_index == '0));               // R1

    AST_TOP_IDLE_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(pred_taken) && $stable(pred_index))); // R7

endmodule

// File: tb/ghist_predictor_tb.sv
module ghist_predictor_tb;

    localparam int W     = 4;
    localparam int DEPTH = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pred_taken;
    logic [W-1:0] pred_index;
    logic         upd_valid = 1'b0;
    logic [W-1:0] upd_index = '0;
    logic         upd_taken = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    int           m_cnt [DEPTH];
    logic [W-1:0] m_hist;

    always #10 clk = ~clk;

    ghist_predictor #(.HIST_W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_taken (pred_taken),
        .pred_index (pred_index),
        .upd_valid  (upd_valid),
        .upd_index  (upd_index),
        .upd_taken  (upd_taken)
    );

    function automatic int sat_next(int c, bit t);
        if (t) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    function automatic bit exp_pred();
        return m_cnt[m_hist] >= 2;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_cnt[i] = 2;
        m_hist = '0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(pred_index == m_hist, {req, " pred_index"}, pred_index, m_hist);
        chk(pred_taken == exp_pred(), {req, " pred_taken"}, pred_taken, exp_pred());
    endtask

    // One clock: drive on the falling edge, update the model at the rising edge, compare after it.
    task automatic step(input bit v, input logic [W-1:0] idx, input bit t, input string req);
        @(negedge clk);
        upd_valid = v;
        upd_index = idx;
        upd_taken = t;
        @(posedge clk);
        if (v) begin
            m_cnt[idx] = sat_next(m_cnt[idx], t);
            m_hist     = {m_hist[W-2:0], t};
        end
        #2;
        compare(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        #2;
        chk(pred_index == '0, "R1 reset history", pred_index, 0);
        chk(pred_taken == 1'b1, "R1 reset prediction", pred_taken, 1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Shift in the bits of target, oldest first, through a scratch index, leaving history == target.
    task automatic steer(input logic [W-1:0] target, input logic [W-1:0] scratch, input string req);
        for (int b = W - 1; b >= 0; b--) step(1'b1, scratch, target[b], req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R3: shift pattern 1,0,1,1 into the history.
        step(1'b1, 4'd0, 1'b1, "R3");
        step(1'b1, 4'd1, 1'b0, "R3");
        step(1'b1, 4'd2, 1'b1, "R3");
        step(1'b1, 4'd5, 1'b1, "R3");
        chk(pred_index == 4'b1011, "R3 history pattern", pred_index, 11);

        // R7: idle cycles leave everything unchanged.
        for (int i = 0; i < 5; i++) step(1'b0, 4'($urandom), 1'($urandom), "R7");
        chk(pred_index == 4'b1011, "R7 history held", pred_index, 11);

        // R4: drive entry 6 up past 3 with stale-index updates, then observe it.
        for (int i = 0; i < 4; i++) step(1'b1, 4'd6, 1'b1, "R4");
        steer(4'd6, 4'd15, "R4");
        chk(pred_taken == 1'b1, "R4 saturated high", pred_taken, 1);
        step(1'b1, 4'd6, 1'b0, "R4");   // 3 -> 2, history becomes 1100
        steer(4'd6, 4'd15, "R4");
        chk(pred_taken == 1'b1, "R4 one step below max", pred_taken, 1);

        // R5: drive entry 9 down past 0, then one taken update leaves it at 1 (not taken).
        for (int i = 0; i < 4; i++) step(1'b1, 4'd9, 1'b0, "R5");
        step(1'b1, 4'd9, 1'b1, "R5");
        steer(4'd9, 4'd14, "R5");
        chk(pred_taken == 1'b0, "R5 clamped at zero", pred_taken, 0);

        // R6: training entry 3 must not disturb entry 12.
        steer(4'd12, 4'd13, "R6");
        for (int i = 0; i < 3; i++) step(1'b1, 4'd3, 1'b0, "R6");
        steer(4'd12, 4'd13, "R6");
        chk(pred_taken == 1'b1, "R6 neighbour untouched", pred_taken, 1);

        // R2: random mix of live-index, stale-index and idle cycles.
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [W-1:0] idx;
            r   = int'($urandom_range(0, 99));
            idx = (r < 60) ? m_hist : 4'($urandom);
            step(r < 85, idx, ($urandom_range(0, 2) != 0), "R2");
        end

        // R1: reset in mid-run restores all counters; sweep the history to look at them.
        do_reset();
        for (int i = 0; i < 40; i++) step(1'b1, 4'd0, 1'($urandom), "R1 sweep");

        // R2: repeating three-branch pattern trained at the live index.
        for (int i = 0; i < 600; i++) step(1'b1, m_hist, (i % 3) == 0, "R2 pattern");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule